// File: doc/BRIEF.md
# Chip-Rate Phase Accumulator

This block sets the rate at which a spreading-code generator steps from one chip to the next. Software loads two words over a 32-bit write port that has a 4-bit address and a strobe: a rate word that is added on every valid sample, and a start word that a sync input copies into the accumulator. The accumulator wraps at a decimal modulus (one hundred million by default) instead of at a power of two. On each wrap it subtracts the modulus and emits a one-cycle chip-advance pulse, which a downstream code generator uses to step to its next chip.

The accumulator value goes out as a port so that a neighbouring block can use the fractional chip phase. The write data bus also appears unchanged on an echo output. Sync has priority over a sample arriving in the same cycle. A write and a sync in the same cycle load the accumulator with the start word held before that write.

Top module: `chip_rate_nco`

## Requirements
- R1: A synchronous active-high reset clears the rate word, the start word and the accumulator to zero, and holds the chip-advance pulse low.
- R2: A strobed write with address 4'h0 loads the rate word from the data bus at that clock edge.
- R3: A strobed write with address 4'h4 loads the start word from the data bus at that clock edge.
- R4: A write with any other address, or with the strobe low, changes neither the rate word nor the start word.
- R5: When sync is high at a clock edge, the accumulator takes the start word held before that edge. A sample in the same cycle is discarded and no pulse is produced.
- R6: When sample-valid is high and sync is low, the accumulator takes its old value plus the rate word, and the result appears after that edge.
- R7: When that sum is greater than or equal to the modulus, the accumulator stores the sum minus the modulus and the chip-advance output is high for exactly the following cycle. A sum exactly equal to the modulus stores zero.
- R8: With sync and sample-valid both low, the accumulator holds its value and the chip-advance output is low.
- R9: The sum is formed one bit wider than the accumulator, so a rate word close to the top of the 32-bit range still produces a wrap rather than a silent overflow. The stored result is the wide sum minus the modulus, taken modulo 2^32.
- R10: The echo output equals the data bus in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 32 | Write data bus |
| wr_addr | input | 4 | Write address |
| wr_strobe | input | 1 | Write qualifier |
| sync | input | 1 | Load the accumulator with the start word |
| sample_valid | input | 1 | Add the rate word on this cycle |
| data_echo | output | 32 | Copy of wr_data |
| acc_out | output | 32 | Current accumulator value |
| chip_tick | output | 1 | One-cycle chip-advance pulse |

## Verification
Register writes show up one edge after the strobe, and they can only be observed through a later sync or sample. Sync and sample results, and the chip-advance pulse, are due exactly one edge after the cycle that carried them. The echo is due in the same cycle. The bench drives each cycle's inputs just after a rising edge and advances a reference model across the next edge. It compares the accumulator and the pulse one time unit after that edge, and it checks the echo shortly after driving it. A small modulus makes it possible to sweep every rate word up to past the modulus, with idle cycles and syncs mixed in.

// File: rtl/chip_rate_pkg.sv
package chip_rate_pkg;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_RATE  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_START = 4'h4;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_RATE  = 2'd1,
        SEL_START = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/chip_rate_regs.sv
module chip_rate_regs
    import chip_rate_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_strobe,
    output logic [W-1:0]      rate_q,
    output logic [W-1:0]      start_q
);

    typedef struct packed {
        logic [W-1:0] rate;
        logic [W-1:0] start;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if (wr_strobe) begin
            unique case (wr_addr)
                ADDR_RATE:  sel = SEL_RATE;
                ADDR_START: sel = SEL_START;
                default:    sel = SEL_NONE;
            endcase
        end

        st_d = st_q;
        case (sel)
            SEL_RATE:  st_d.rate  = wr_data;
            SEL_START: st_d.start = wr_data;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_q  = st_q.rate;
    assign start_q = st_q.start;

endmodule

// File: rtl/chip_rate_accum.sv
module chip_rate_accum #(
    parameter int unsigned W       = 32,
    parameter int unsigned MODULUS = 100_000_000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sync,
    input  logic         sample_valid,
    input  logic [W-1:0] rate,
    input  logic [W-1:0] start,
    output logic [W-1:0] acc_q_o,
    output logic         tick_q_o
);

    localparam int unsigned SW    = W + 1;
    localparam logic [SW-1:0] MOD_X = SW'(MODULUS);

    typedef struct packed {
        logic [W-1:0] acc;
        logic         tick;
    } acc_t;

    acc_t          st_d, st_q;
    logic [SW-1:0] sum_wide;
    logic [SW-1:0] sum_wrapped;
    logic          wraps;

    always_comb begin
        sum_wide    = {1'b0, st_q.acc} + {1'b0, rate};
        wraps       = (sum_wide >= MOD_X);
        sum_wrapped = sum_wide - MOD_X;

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (sync) begin
            st_d.acc = start;
        end else if (sample_valid) begin
            if (wraps) begin
                st_d.acc  = sum_wrapped[W-1:0];
                st_d.tick = 1'b1;
            end else begin
                st_d.acc  = sum_wide[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q_o  = st_q.acc;
    assign tick_q_o = st_q.tick;

endmodule

// File: rtl/chip_rate_nco.sv
module chip_rate_nco #(
    parameter int unsigned W       = 32,
    parameter int unsigned MODULUS = 100_000_000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] wr_data,
    input  logic [3:0]   wr_addr,
    input  logic         wr_strobe,
    input  logic         sync,
    input  logic         sample_valid,
    output logic [W-1:0] data_echo,
    output logic [W-1:0] acc_out,
    output logic         chip_tick
);

    logic [W-1:0] rate_w;
    logic [W-1:0] start_w;

    chip_rate_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_data   (wr_data),
        .wr_addr   (wr_addr),
        .wr_strobe (wr_strobe),
        .rate_q    (rate_w),
        .start_q   (start_w)
    );

    chip_rate_accum #(.W(W), .MODULUS(MODULUS)) u_accum (
        .clk          (clk),
        .rst          (rst),
        .sync         (sync),
        .sample_valid (sample_valid),
        .rate         (rate_w),
        .start        (start_w),
        .acc_q_o      (acc_out),
        .tick_q_o     (chip_tick)
    );

    assign data_echo = wr_data;

endmodule

module chip_rate_nco_chk #(
    parameter int unsigned W       = 32,
    parameter int unsigned MODULUS = 100_000_000
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] wr_data,
    input logic [3:0]   wr_addr,
    input logic         wr_strobe,
    input logic         sync,
    input logic         sample_valid,
    input logic [W-1:0] data_echo,
    input logic [W-1:0] acc_out,
    input logic         chip_tick,
    input logic [W-1:0] rate_w,
    input logic [W-1:0] start_w
);

    localparam logic [W:0] MOD_X = (W+1)'(MODULUS);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) === 1'b1 |-> acc_out == '0 && !chip_tick && rate_w == '0 && start_w == '0);

    p_other_addr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(wr_strobe) && $past(wr_addr) != 4'h0 && $past(wr_addr) != 4'h4
        |-> $stable(rate_w) && $stable(start_w));

    p_sync_load_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(sync) |-> acc_out == $past(start_w) && !chip_tick);

    p_wrap_flag_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(sample_valid) && !$past(sync)
        |-> chip_tick == (({1'b0, $past(acc_out)} + {1'b0, $past(rate_w)}) >= MOD_X));

    p_tick_cause_r7: assert property (@(posedge clk) disable iff (rst)
        chip_tick |-> $past(sample_valid) && !$past(sync));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(sync) && !$past(sample_valid) |-> $stable(acc_out) && !chip_tick);

    p_echo_r10: assert property (@(posedge clk) disable iff (rst)
        data_echo == wr_data);

endmodule

bind chip_rate_nco chip_rate_nco_chk #(.W(W), .MODULUS(MODULUS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_data      (wr_data),
    .wr_addr      (wr_addr),
    .wr_strobe    (wr_strobe),
    .sync         (sync),
    .sample_valid (sample_valid),
    .data_echo    (data_echo),
    .acc_out      (acc_out),
    .chip_tick    (chip_tick),
    .rate_w       (rate_w),
    .start_w      (start_w)
);

// File: tb/tb_chip_rate_nco.sv
module tb_chip_rate_nco;

    localparam int unsigned W       = 32;
    localparam int unsigned MOD     = 53;
    localparam time         CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic [3:0]   wr_addr = '0;
    logic         wr_strobe = 1'b0;
    logic         sync = 1'b0;
    logic         sample_valid = 1'b0;
    logic [W-1:0] data_echo;
    logic [W-1:0] acc_out;
    logic         chip_tick;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_rate = '0;
    logic [W-1:0] m_start = '0;
    logic [W-1:0] m_acc = '0;
    logic         m_tick = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    chip_rate_nco #(.W(W), .MODULUS(MOD)) dut (
        .clk          (clk),
        .rst          (rst),
        .wr_data      (wr_data),
        .wr_addr      (wr_addr),
        .wr_strobe    (wr_strobe),
        .sync         (sync),
        .sample_valid (sample_valid),
        .data_echo    (data_echo),
        .acc_out      (acc_out),
        .chip_tick    (chip_tick)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive inputs, advance model, compare after the edge
    task automatic cycle(input logic stb, input logic [3:0] addr, input logic [W-1:0] data,
                         input logic syn, input logic smp, input string req);
        logic [W:0] sum;
        wr_strobe    = stb;
        wr_addr      = addr;
        wr_data      = data;
        sync         = syn;
        sample_valid = smp;
        #1;
        check("R10", data_echo, data);
        sum    = {1'b0, m_acc} + {1'b0, m_rate};
        m_tick = 1'b0;
        if (syn) begin
            m_acc = m_start;
        end else if (smp) begin
            if (sum >= (W+1)'(MOD)) begin
                sum    = sum - (W+1)'(MOD);
                m_acc  = sum[W-1:0];
                m_tick = 1'b1;
            end else begin
                m_acc = sum[W-1:0];
            end
        end
        if (stb && addr == 4'h0) m_rate  = data;
        if (stb && addr == 4'h4) m_start = data;
        @(posedge clk);
        #1;
        check(req, acc_out, m_acc);
        check(req, {{(W-1){1'b0}}, chip_tick}, {{(W-1){1'b0}}, m_tick});
    endtask

    task automatic wr(input logic [3:0] addr, input logic [W-1:0] data, input string req);
        cycle(1'b1, addr, data, 1'b0, 1'b0, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", acc_out, '0);
        check("R1", {{(W-1){1'b0}}, chip_tick}, '0);
        rst = 1'b0;
        // R1: registers zero, sample adds zero rate
        cycle(1'b0, 4'h0, '0, 1'b0, 1'b1, "R1");

        // R2: rate load observed through a sample from zero
        wr(4'h0, 32'd17, "R2");
        cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, "R5");
        cycle(1'b0, 4'h0, '0, 1'b0, 1'b1, "R2");
        check("R2", acc_out, 32'd17);
        // R3: start load observed through sync
        wr(4'h4, 32'd9, "R3");
        cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, "R3");
        check("R3", acc_out, 32'd9);

        // R4: other addresses and unstrobed writes are ignored
        wr(4'h8, 32'd40, "R4");
        wr(4'hC, 32'd41, "R4");
        wr(4'h1, 32'd42, "R4");
        wr(4'h5, 32'd43, "R4");
        cycle(1'b0, 4'h0, 32'd44, 1'b0, 1'b0, "R4");
        cycle(1'b0, 4'h4, 32'd45, 1'b1, 1'b0, "R4");
        check("R4", acc_out, 32'd9);
        cycle(1'b0, 4'h0, '0, 1'b0, 1'b1, "R4");
        check("R4", acc_out, 32'd26);

        // R5: sync wins over sample; write plus sync uses the old start word
        cycle(1'b0, 4'h0, '0, 1'b1, 1'b1, "R5");
        check("R5", acc_out, 32'd9);
        cycle(1'b1, 4'h4, 32'd30, 1'b1, 1'b0, "R5");
        check("R5", acc_out, 32'd9);
        cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, "R5");
        check("R5", acc_out, 32'd30);

        // R7: sum equal to the modulus stores zero and ticks
        wr(4'h4, 32'd0, "R7");
        wr(4'h0, 32'd53, "R7");
        cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, "R5");
        cycle(1'b0, 4'h0, '0, 1'b0, 1'b1, "R7");
        check("R7", acc_out, 32'd0);
        check("R7", {{(W-1){1'b0}}, chip_tick}, 32'd1);
        cycle(1'b0, 4'h0, '0, 1'b0, 1'b0, "R8");
        check("R7", {{(W-1){1'b0}}, chip_tick}, 32'd0);

        // R9: rate near the top of the range
        wr(4'h0, 32'hFFFF_FFF0, "R9");
        wr(4'h4, 32'd20, "R9");
        cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, "R5");
        cycle(1'b0, 4'h0, '0, 1'b0, 1'b1, "R9");
        check("R9", acc_out, 32'hFFFF_FFCF);
        check("R9", {{(W-1){1'b0}}, chip_tick}, 32'd1);

        // Sweep all rate words 0..MOD+7 with mixed idle cycles and syncs
        for (int f = 0; f <= int'(MOD) + 7; f++) begin
            wr(4'h0, W'(f), "R2");
            wr(4'h4, W'((f * 7) % int'(MOD)), "R3");
            cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, "R5");
            for (int k = 0; k < 40; k++) begin
                if (k == 23)
                    cycle(1'b0, 4'h0, W'(k), 1'b1, 1'b1, "R5");
                else if (k % 5 == 4)
                    cycle(1'b0, 4'h0, W'(k), 1'b0, 1'b0, "R8");
                else
                    cycle(1'b0, 4'h0, W'(k), 1'b0, 1'b1, m_tick ? "R7" : "R6");
            end
        end

        // R1: reset mid-run clears everything
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", acc_out, '0);
        check("R1", {{(W-1){1'b0}}, chip_tick}, '0);
        rst = 1'b0;
        m_rate = '0; m_start = '0; m_acc = '0; m_tick = 1'b0;
        cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, "R1");
        cycle(1'b0, 4'h0, '0, 1'b0, 1'b1, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule